// File: doc/BRIEF.md
# Hamming-Protected Word Memory

This block is a small synchronous memory that guards every stored data word with a Hamming single-error-correcting code. On a write it derives the check bits from the incoming data and stores data and check bits together as one codeword. On a read it derives a fresh set of check bits from the fetched data bits and compares them with the stored ones. The difference, called the syndrome, decides what happens next. The data can pass through clean. A single flipped data bit can be repaired. A fault in a check bit only can be reported without touching the data. A syndrome that points outside the codeword can be flagged as uncorrectable.

A client writes through a simple enable/address/data port and reads through an enable/address port. The result, a valid strobe and two status flags appear one cycle after the read request. A fault-injection mask on the write path lets a test flip any chosen set of codeword bits as they are stored. This makes single-bit and multi-bit faults reproducible at known positions.

Top module: `hsec_ecc_mem`

## Requirements
- R1: With 8 data bits the code uses 4 check bits, the smallest count k with 2^k-1 >= 8+k. The codeword is 12 bits, and position p (1..12) is held in codeword bit p-1. Check bits sit at positions 1, 2, 4 and 8. Data bits d0..d7 sit at positions 3, 5, 6, 7, 9, 10, 11 and 12 in that order. Bit p-1 of the injection mask flips position p.
- R2: The check bit at position 2^i is chosen so that all positions whose index has bit i set together hold an even number of ones.
- R3: When wr_en is high at a rising clock edge, the codeword of wr_data, XORed with inj_mask, is stored at wr_addr.
- R4: When rd_en is high at a rising edge, rd_valid is high in the following cycle, and rd_data and both flags belong to that read. Otherwise rd_valid is low in the following cycle, and rd_data and both flags are zero while rd_valid is low.
- R5: A syndrome of zero returns the stored data unchanged, with both flags low.
- R6: A syndrome with exactly one bit set, meaning a check-bit fault, returns the data unchanged with err_corrected high and err_uncorrectable low.
- R7: A syndrome from 3 to 12 with two or more bits set inverts the data bit at that position before output, with err_corrected high.
- R8: A syndrome of 13, 14 or 15 raises err_uncorrectable, keeps err_corrected low and returns the fetched data bits unmodified.
- R9: err_corrected and err_uncorrectable are never high together.
- R10: A synchronous reset clears every word to the all-zero codeword and drops rd_valid. After reset, any address reads as zero with both flags low.
- R11: A read and a write to the same address at the same edge return the contents held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, all state changes on the rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Write request |
| wr_addr | input | 4 | Write word address |
| wr_data | input | 8 | Data to store |
| inj_mask | input | 12 | Codeword bits to flip on the write path |
| rd_en | input | 1 | Read request |
| rd_addr | input | 4 | Read word address |
| rd_data | output | 8 | Corrected read data |
| rd_valid | output | 1 | Read result present this cycle |
| err_corrected | output | 1 | Single fault repaired or check-bit fault seen |
| err_uncorrectable | output | 1 | Syndrome points outside the codeword |

## Verification
A wrong check-bit group or a misplaced data bit gives a nonzero syndrome on a word written with a clean mask. That fault shows on the very next read as a spurious corrected flag or altered data. A wrong syndrome-to-position map shows as the wrong bit inverted on the first single-bit injection at an affected position. A misplaced classification boundary shows as the wrong flag on the directed reads whose syndromes are 12, 13, 14 and 15. A stored word or read register that misbehaves is seen one cycle after the read request, in rd_data or in the timing of rd_valid.

// File: rtl/hsec_pkg.sv
// Package hsec_pkg
// Shared compile-time helpers for the Hamming-protected memory: check-bit
// count, position map of data bits, and per-check-bit coverage masks.
// Assumes data widths of at most 64 bits.
package hsec_pkg;

    // Smallest k such that 2^k - 1 >= m + k.
    function automatic int chk_bits(int m);
        int k;
        k = 1;
        while (((1 << k) - 1) < (m + k)) k++;
        return k;
    endfunction

    // True when p is a positive power of two.
    function automatic bit is_pow2(int p);
        return (p > 0) && ((p & (p - 1)) == 0);
    endfunction

    // 1-based codeword position of data bit j (non-power-of-two slots in order).
    function automatic int data_pos(int j);
        int res;
        int cnt;
        res = 0;
        cnt = 0;
        for (int p = 1; p < 256; p++) begin
            if (!is_pow2(p)) begin
                if (cnt == j && res == 0) res = p;
                cnt++;
            end
        end
        return res;
    endfunction

    // Data bits whose position index has bit i set.
    function automatic logic [63:0] cover_mask(int i, int m);
        logic [63:0] msk;
        msk = '0;
        for (int j = 0; j < m; j++) begin
            if (((data_pos(j) >> i) & 1) == 1) msk[j] = 1'b1;
        end
        return msk;
    endfunction

endpackage

// File: rtl/hsec_encoder.sv
// Module hsec_encoder
// Computes the Hamming check bits for one data word, each chosen for even
// parity over its covered positions. Purely combinational.
// Assumes DATA_W <= 64.
module hsec_encoder #(
    parameter int DATA_W = 8,
    localparam int CHK_W = hsec_pkg::chk_bits(DATA_W)
) (
    input  logic [DATA_W-1:0] data_i,
    output logic [CHK_W-1:0]  chk_o
);

    // One parity tree per check bit over the data bits it covers.
    for (genvar i = 0; i < CHK_W; i++) begin : g_chk
        localparam logic [63:0] COVER = hsec_pkg::cover_mask(i, DATA_W);
        assign chk_o[i] = ^(data_i & COVER[DATA_W-1:0]);
    end

endmodule

// File: rtl/hsec_store.sv
// Module hsec_store
// Codeword array with a synchronous write and a one-cycle registered read.
// A read and a write at one edge return the old contents. Reset clears all
// words and the read register.
module hsec_store #(
    parameter int ADDR_W = 4,
    parameter int WORD_W = 12,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_word,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [WORD_W-1:0] rd_word,
    output logic              rd_valid
);

    logic [WORD_W-1:0] mem [DEPTH];

    // Array update: clear on reset, else store the incoming codeword.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int a = 0; a < DEPTH; a++) mem[a] <= '0;
        end else if (wr_en) begin
            mem[wr_addr] <= wr_word;
        end
    end

    // Read register: capture the addressed word and the valid strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_word  <= '0;
            rd_valid <= 1'b0;
        end else begin
            if (rd_en) rd_word <= mem[rd_addr];
            rd_valid <= rd_en;
        end
    end

endmodule

// File: rtl/hsec_decoder.sv
// Module hsec_decoder
// Splits a fetched codeword, forms the syndrome against freshly computed
// check bits, and classifies it: clean, check-bit fault, data-bit fault
// (corrected by position) or out of range (uncorrectable).
// Outputs are zero while valid_i is low.
module hsec_decoder #(
    parameter int DATA_W = 8,
    localparam int CHK_W = hsec_pkg::chk_bits(DATA_W),
    localparam int CW_W  = DATA_W + CHK_W
) (
    input  logic              valid_i,
    input  logic [CW_W-1:0]   cw_i,
    output logic [DATA_W-1:0] data_o,
    output logic              corrected_o,
    output logic              uncorr_o
);

    logic [DATA_W-1:0] data_raw;
    logic [CHK_W-1:0]  chk_stored;
    logic [CHK_W-1:0]  chk_fresh;
    logic [CHK_W-1:0]  syn;
    logic [DATA_W-1:0] flip_vec;
    logic [DATA_W-1:0] data_fix;
    logic              corr_c;
    logic              unc_c;

    // Data bits: pull from their positions and build the flip selector.
    for (genvar j = 0; j < DATA_W; j++) begin : g_dat
        localparam int P = hsec_pkg::data_pos(j);
        assign data_raw[j] = cw_i[P-1];
        assign flip_vec[j] = (int'(syn) == P);
    end

    // Check bits: pull from the power-of-two positions.
    for (genvar i = 0; i < CHK_W; i++) begin : g_chk
        assign chk_stored[i] = cw_i[(1 << i) - 1];
    end

    hsec_encoder #(.DATA_W(DATA_W)) u_recalc (
        .data_i (data_raw),
        .chk_o  (chk_fresh)
    );

    assign syn = chk_fresh ^ chk_stored;

    // Syndrome classification and correction.
    always_comb begin
        data_fix = data_raw;
        corr_c   = 1'b0;
        unc_c    = 1'b0;
        if (syn == '0) begin
            corr_c = 1'b0;
        end else if ($countones(syn) == 1) begin
            corr_c = 1'b1;
        end else if (int'(syn) > CW_W) begin
            unc_c = 1'b1;
        end else begin
            corr_c   = 1'b1;
            data_fix = data_raw ^ flip_vec;
        end
    end

    // Output gating by the read strobe.
    assign data_o      = valid_i ? data_fix : '0;
    assign corrected_o = valid_i & corr_c;
    assign uncorr_o    = valid_i & unc_c;

    // Outcome checks against the fetched data bits.
    always_comb begin
        if (valid_i && syn == '0)
            AST_CLEAN_PASS: assert (data_o == data_raw && !corrected_o && !uncorr_o); // R5
        if (valid_i && $countones(syn) == 1)
            AST_CHKBIT_PASS: assert (data_o == data_raw && corrected_o && !uncorr_o); // R6
        if (valid_i && $countones(syn) > 1 && int'(syn) <= CW_W)
            AST_ONE_BIT_FIX: assert ($countones(data_o ^ data_raw) == 1 && corrected_o); // R7
        if (valid_i && int'(syn) > CW_W)
            AST_OUT_OF_RANGE: assert (data_o == data_raw && uncorr_o && !corrected_o); // R8
    end

endmodule

// File: rtl/hsec_ecc_mem.sv
// Module hsec_ecc_mem
// Top of the Hamming-protected memory: encodes write data, applies the
// fault-injection mask, stores the codeword, and decodes the registered
// read word. Result, valid and flags appear one cycle after rd_en.
// Assumes a synchronous active-low reset held for at least one edge.
module hsec_ecc_mem #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 4,
    localparam int CHK_W = hsec_pkg::chk_bits(DATA_W),
    localparam int CW_W  = DATA_W + CHK_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [CW_W-1:0]   inj_mask,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              err_corrected,
    output logic              err_uncorrectable
);

    logic [CHK_W-1:0] wr_chk;
    logic [CW_W-1:0]  wr_cw;
    logic [CW_W-1:0]  rd_cw;

    hsec_encoder #(.DATA_W(DATA_W)) u_enc (
        .data_i (wr_data),
        .chk_o  (wr_chk)
    );

    // Codeword assembly: data bits into non-power-of-two positions.
    for (genvar j = 0; j < DATA_W; j++) begin : g_pack_d
        localparam int P = hsec_pkg::data_pos(j);
        assign wr_cw[P-1] = wr_data[j] ^ inj_mask[P-1];
    end

    // Codeword assembly: check bits into power-of-two positions.
    for (genvar i = 0; i < CHK_W; i++) begin : g_pack_c
        assign wr_cw[(1 << i) - 1] = wr_chk[i] ^ inj_mask[(1 << i) - 1];
    end

    hsec_store #(.ADDR_W(ADDR_W), .WORD_W(CW_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_word  (wr_cw),
        .rd_en    (rd_en),
        .rd_addr  (rd_addr),
        .rd_word  (rd_cw),
        .rd_valid (rd_valid)
    );

    hsec_decoder #(.DATA_W(DATA_W)) u_dec (
        .valid_i     (rd_valid),
        .cw_i        (rd_cw),
        .data_o      (rd_data),
        .corrected_o (err_corrected),
        .uncorr_o    (err_uncorrectable)
    );

    AST_VALID_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid); // R4
    AST_NO_STRAY_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rd_valid); // R4
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |-> (rd_data == '0 && !err_corrected && !err_uncorrectable)); // R4
    AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(err_corrected && err_uncorrectable)); // R9
    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> !rd_valid); // R10

endmodule

// File: tb/hsec_ecc_mem_bench.sv
// Bench for hsec_ecc_mem: directed corner cases plus seeded random traffic,
// checked against a reference model built from the requirements.
module hsec_ecc_mem_bench;

    localparam int CLK_PERIOD = 10;
    localparam int DPOS [8] = '{3, 5, 6, 7, 9, 10, 11, 12}; // R1 data positions

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic [11:0] inj_mask = '0;
    logic        rd_en = 1'b0;
    logic [3:0]  rd_addr = '0;
    logic [7:0]  rd_data;
    logic        rd_valid;
    logic        err_corrected;
    logic        err_uncorrectable;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [11:0] mem_m [16];

    always #(CLK_PERIOD / 2) clk = ~clk;

    hsec_ecc_mem u_hsec_ecc_mem (
        .clk (clk), .rst_n (rst_n),
        .wr_en (wr_en), .wr_addr (wr_addr), .wr_data (wr_data), .inj_mask (inj_mask),
        .rd_en (rd_en), .rd_addr (rd_addr),
        .rd_data (rd_data), .rd_valid (rd_valid),
        .err_corrected (err_corrected), .err_uncorrectable (err_uncorrectable)
    );

    // Reference encoder from R1/R2.
    function automatic logic [11:0] ref_encode(logic [7:0] d);
        logic [11:0] cw;
        cw = '0;
        for (int j = 0; j < 8; j++) cw[DPOS[j]-1] = d[j];
        for (int i = 0; i < 4; i++) begin
            logic par;
            par = 1'b0;
            for (int j = 0; j < 8; j++) if (DPOS[j][i]) par ^= d[j];
            cw[(1 << i) - 1] = par;
        end
        return cw;
    endfunction

    // Reference decoder from R5-R8: returns {uncorrectable, corrected, data}.
    function automatic logic [9:0] ref_decode(logic [11:0] cw);
        logic [7:0] d;
        logic [3:0] syn;
        logic cor;
        logic unc;
        for (int j = 0; j < 8; j++) d[j] = cw[DPOS[j]-1];
        for (int i = 0; i < 4; i++) begin
            logic par;
            par = cw[(1 << i) - 1];
            for (int j = 0; j < 8; j++) if (DPOS[j][i]) par ^= d[j];
            syn[i] = par;
        end
        cor = 1'b0;
        unc = 1'b0;
        if (syn == 4'd0) cor = 1'b0;
        else if (syn == 4'd1 || syn == 4'd2 || syn == 4'd4 || syn == 4'd8) cor = 1'b1;
        else if (syn > 4'd12) unc = 1'b1;
        else begin
            cor = 1'b1;
            for (int j = 0; j < 8; j++) if (DPOS[j] == int'(syn)) d[j] = ~d[j];
        end
        return {unc, cor, d};
    endfunction

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // One cycle of traffic; called at a falling edge, returns at the next one.
    task automatic step(string req, bit we, logic [3:0] wa, logic [7:0] wd,
                        logic [11:0] msk, bit re, logic [3:0] ra);
        logic [9:0] exp;
        wr_en = we; wr_addr = wa; wr_data = wd; inj_mask = msk;
        rd_en = re; rd_addr = ra;
        exp = ref_decode(mem_m[ra]);          // R11: sampled before the write
        if (we) mem_m[wa] = ref_encode(wd) ^ msk;
        @(posedge clk);
        @(negedge clk);
        if (re) begin
            check(req, "rd_valid", 32'(rd_valid), 32'd1);
            check(req, "rd_data", 32'(rd_data), 32'(exp[7:0]));
            check(req, "err_corrected", 32'(err_corrected), 32'(exp[8]));
            check(req, "err_uncorrectable", 32'(err_uncorrectable), 32'(exp[9]));
        end else begin
            check("R4", "idle rd_valid", 32'(rd_valid), 32'd0);
            check("R4", "idle outputs", {rd_data, err_corrected, err_uncorrectable}, 32'd0);
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int a = 0; a < 16; a++) mem_m[a] = '0;
        repeat (3) @(negedge clk);
        check("R10", "rd_valid in reset", 32'(rd_valid), 32'd0);
        rst_n = 1'b1;

        // R10: every word reads as zero, clean.
        for (int a = 0; a < 16; a++) step("R10", 0, 4'd0, 8'd0, 12'd0, 1, 4'(a));
        step("R4", 0, 4'd0, 8'd0, 12'd0, 0, 4'd0);

        // R3/R5: clean write then read.
        step("R3", 1, 4'd2, 8'h5C, 12'd0, 0, 4'd0);
        step("R5", 0, 4'd0, 8'd0, 12'd0, 1, 4'd2);

        // R1/R6/R7: single flip at every position.
        for (int p = 1; p <= 12; p++) begin
            step("R1", 1, 4'd3, 8'hA5, 12'(1 << (p - 1)), 0, 4'd0);
            if (p == 1 || p == 2 || p == 4 || p == 8)
                step("R6", 0, 4'd0, 8'd0, 12'd0, 1, 4'd3);
            else
                step("R7", 0, 4'd0, 8'd0, 12'd0, 1, 4'd3);
        end

        // R2: all-ones data with no fault is clean.
        step("R2", 1, 4'd4, 8'hFF, 12'd0, 0, 4'd0);
        step("R2", 0, 4'd0, 8'd0, 12'd0, 1, 4'd4);

        // R8: syndromes 13, 14, 15 via paired faults with position 12.
        step("R8", 1, 4'd6, 8'h3C, 12'h801, 0, 4'd0);
        step("R8", 0, 4'd0, 8'd0, 12'd0, 1, 4'd6);
        step("R8", 1, 4'd6, 8'hC3, 12'h802, 0, 4'd0);
        step("R8", 0, 4'd0, 8'd0, 12'd0, 1, 4'd6);
        step("R8", 1, 4'd6, 8'h96, 12'h804, 0, 4'd0);
        step("R8", 0, 4'd0, 8'd0, 12'd0, 1, 4'd6);
        // R7 boundary: syndrome 12 lands on the last data bit.
        step("R7", 1, 4'd6, 8'h00, 12'h800, 0, 4'd0);
        step("R7", 0, 4'd0, 8'd0, 12'd0, 1, 4'd6);

        // R11: read and write same address at one edge return old contents.
        step("R11", 1, 4'd2, 8'h11, 12'd0, 1, 4'd2);
        step("R11", 0, 4'd0, 8'd0, 12'd0, 1, 4'd2);

        // Random traffic with mixed fault masks; R9 covered by the flag checks.
        for (int n = 0; n < 400; n++) begin
            logic [11:0] msk;
            int sel;
            int b0;
            int b1;
            sel = int'($urandom % 4);
            b0 = int'($urandom % 12);
            b1 = (b0 + 1 + int'($urandom % 11)) % 12;
            case (sel)
                0: msk = '0;
                1: msk = 12'(1 << b0);
                2: msk = 12'((1 << b0) | (1 << b1));
                default: msk = 12'($urandom);
            endcase
            step("R9", ($urandom % 2) == 1, 4'($urandom), 8'($urandom), msk,
                 ($urandom % 4) != 0, 4'($urandom));
        end
        step("R4", 0, 4'd0, 8'd0, 12'd0, 0, 4'd0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule